// File: doc/BRIEF.md
# Packed Color Lookup Table

This block holds the color table for an indexed-pixel display path. Software sees the table as a window of 128 32-bit words. Each word carries two 16-bit color entries, so the table has 256 entries in all. Software can write any word and read back exactly what it stored.

A separate lookup port serves the pixel pipeline. It takes an 8-bit pixel index and, one clock later, returns a 24-bit color. The color is built from the three 5-bit fields of the selected entry. Each field is widened to 8 bits by placing three zero bits below it. A channel-order input can exchange the red and blue bytes of the result.

The register window addresses words, not bytes. Word n corresponds to byte offset 0x200 + 4n in the wider register map. Decode of that wider map happens outside this block.

Top module: `clut_store`

## Requirements
- R1: Word n holds entry 2n in bits [15:0] and entry 2n+1 in bits [31:16]. Pixel index i selects word i>>1, and bit 0 of the index selects the halfword (0 = low, 1 = high).
- R2: Within an entry, red is bits [4:0], green is bits [9:5] and blue is bits [14:10]. With `swap_rb` low, `pix_rgb` carries red in [23:16], green in [15:8] and blue in [7:0].
- R3: Each 5-bit field appears as the top 5 bits of its 8-bit output byte, and the three low bits of every byte are zero.
- R4: Bit 15 of an entry has no effect on the color returned.
- R5: `reg_rdata` returns the full 32-bit word last written to the word that `reg_word` addressed one cycle earlier, including bits 15 and 31.
- R6: With `swap_rb` high in the lookup cycle, the red and blue output bytes are exchanged and green is unchanged.
- R7: `pix_rgb` reflects the `pix_idx` and `swap_rb` of the previous cycle. A write to the word being looked up in that same cycle yields the value the word held before the write.
- R8: Reset clears every word to zero, so that readback gives 0 and every lookup gives 0.
- R9: When index and swap are held and no write occurred in the preceding cycle, `pix_rgb` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Write strobe for the register window |
| reg_word | input | 7 | Word address within the window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered readback of the addressed word |
| pix_idx | input | 8 | Pixel index for lookup |
| swap_rb | input | 1 | Exchange red and blue outputs |
| pix_rgb | output | 24 | Registered expanded color |

## Verification
The table is first read after reset to confirm that it is all zero. It is then filled with hashed words in which bits 15 and 31 vary, and all of it is read back. This sweep catches address, halfword and masking faults.

Every one of the 256 indices is then looked up, once in normal channel order and once swapped. Comparing the results against arithmetic expansion separates field-position errors from shift errors and from leakage of bit 15. Finally, a lookup placed in the same cycle as a write to that word shows whether old or new data is returned.

// File: rtl/clut_pkg.sv
package clut_pkg;
  localparam int FIELD_W = 5;
  localparam int CHAN_W  = 8;
  localparam int ENTRY_W = 16;
  localparam int RGB_W   = 3 * CHAN_W;

  // widen a 5-bit field by appending zeros below it
  function automatic logic [CHAN_W-1:0] widen(input logic [FIELD_W-1:0] f);
    return {f, {(CHAN_W-FIELD_W){1'b0}}};
  endfunction

  // entry to {red, green, blue}; bit 15 is not used
  function automatic logic [RGB_W-1:0] entry_rgb(input logic [ENTRY_W-1:0] e,
                                                 input logic swap);
    logic [CHAN_W-1:0] r, g, b;
    r = widen(e[FIELD_W-1:0]);
    g = widen(e[2*FIELD_W-1:FIELD_W]);
    b = widen(e[3*FIELD_W-1:2*FIELD_W]);
    return swap ? {b, g, r} : {r, g, b};
  endfunction
endpackage

// File: rtl/clut_ram.sv
module clut_ram #(
  parameter int WORDS = 128,
  parameter int DW    = 32,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_q,
  input  logic [AW-1:0] lk_addr,
  output logic [DW-1:0] lk_q
);
  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
      rd_q <= '0;
      lk_q <= '0;
    end else begin
      if (wr_en) mem[wr_addr] <= wr_data;
      rd_q <= mem[rd_addr];
      lk_q <= mem[lk_addr];
    end
  end

  wire lk_collide = wr_en && (lk_addr == wr_addr);

  // R7: a colliding lookup sees the pre-write contents
  a_r7_old_on_collide: assert property (@(posedge clk) disable iff (!rst_n)
    lk_collide |=> lk_q == $past(mem[wr_addr]));

  // R5: a write lands in the addressed word
  a_r5_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> mem[$past(wr_addr)] == $past(wr_data));
endmodule

// File: rtl/clut_expand.sv
module clut_expand
  import clut_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0]    word_in,
  input  logic             hi_sel,
  input  logic             swap,
  output logic [RGB_W-1:0] rgb
);
  logic [ENTRY_W-1:0] entry;
  always_comb begin
    entry = hi_sel ? word_in[2*ENTRY_W-1:ENTRY_W] : word_in[ENTRY_W-1:0];
    rgb   = entry_rgb(entry, swap);
  end
endmodule

// File: rtl/clut_store.sv
module clut_store
  import clut_pkg::*;
#(
  parameter int WORDS = 128,
  localparam int AW   = $clog2(WORDS),
  localparam int IW   = AW + 1,
  localparam int DW   = 2 * ENTRY_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [AW-1:0]    reg_word,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic [IW-1:0]    pix_idx,
  input  logic             swap_rb,
  output logic [RGB_W-1:0] pix_rgb
);
  logic [DW-1:0] lk_word;
  logic          hi_q, swap_q;

  clut_ram #(.WORDS(WORDS), .DW(DW)) ram_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(reg_we), .wr_addr(reg_word), .wr_data(reg_wdata),
    .rd_addr(reg_word), .rd_q(reg_rdata),
    .lk_addr(pix_idx[IW-1:1]), .lk_q(lk_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q   <= 1'b0;
      swap_q <= 1'b0;
    end else begin
      hi_q   <= pix_idx[0];
      swap_q <= swap_rb;
    end
  end

  clut_expand #(.DW(DW)) exp_i (
    .word_in(lk_word), .hi_sel(hi_q), .swap(swap_q), .rgb(pix_rgb)
  );

  // R3: low three bits of each byte stay zero
  a_r3_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    pix_rgb[18:16] == 3'b0 && pix_rgb[10:8] == 3'b0 && pix_rgb[2:0] == 3'b0);

  // R9: held lookup with no prior write keeps the output
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(pix_idx) && $stable(swap_rb) && !$past(reg_we) |=> $stable(pix_rgb));
endmodule

// File: tb/clut_store_tb.sv
module clut_store_tb_top;
  logic clk = 0, rst_n = 0, reg_we = 0, swap_rb = 0;
  logic [6:0] reg_word = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [7:0] pix_idx = 0;
  logic [23:0] pix_rgb;
  int errs = 0, checks = 0;
  logic [31:0] model [128];

  always #5 clk = ~clk;

  clut_store dut_i (.*);

  function automatic logic [31:0] pat(int n);
    return (n * 32'h9E3779B1) ^ (n[0] ? 32'h8000_0000 : 32'h0000_8000) ^ (n << 9);
  endfunction

  function automatic logic [23:0] want(logic [31:0] w, int hi, int sw);
    int e, r, g, b;
    e = hi ? int'(w >> 16) & 32'hFFFF : int'(w) & 32'hFFFF;
    r = (e % 32) * 8;
    g = ((e / 32) % 32) * 8;
    b = ((e / 1024) % 32) * 8;
    if (sw) return {b[7:0], g[7:0], r[7:0]};
    return {r[7:0], g[7:0], b[7:0]};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, registers update at posedge, sample at next negedge
  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    #1900000;
    errs++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst_n = 1;
    // R8: reset contents
    for (int n = 0; n < 128; n++) begin
      reg_word = 7'(n); step();
      chk("R8 readback", reg_rdata, 0);
    end
    for (int i = 0; i < 256; i += 37) begin
      pix_idx = 8'(i); step();
      chk("R8 lookup", {8'h0, pix_rgb}, 0);
    end
    // fill
    for (int n = 0; n < 128; n++) begin
      model[n] = pat(n);
      reg_we = 1; reg_word = 7'(n); reg_wdata = model[n]; step();
    end
    reg_we = 0;
    // R5 readback
    for (int n = 0; n < 128; n++) begin
      reg_word = 7'(n); step();
      chk("R5 readback", reg_rdata, model[n]);
    end
    // R1 R2 R3 R4 normal order; R6 swapped
    for (int sw = 0; sw < 2; sw++)
      for (int i = 0; i < 256; i++) begin
        pix_idx = 8'(i); swap_rb = sw[0]; step();
        chk(sw ? "R6 swap" : "R1 R2 R3 R4 lookup", {8'h0, pix_rgb},
            {8'h0, want(model[i/2], i%2, sw)});
      end
    // R4 explicit: toggle only bit 15 / 31
    reg_we = 1; reg_word = 7'd5; reg_wdata = model[5] ^ 32'h8000_8000; step();
    reg_we = 0; pix_idx = 8'd10; swap_rb = 0; step();
    chk("R4 intensity lo", {8'h0, pix_rgb}, {8'h0, want(model[5], 0, 0)});
    pix_idx = 8'd11; step();
    chk("R4 intensity hi", {8'h0, pix_rgb}, {8'h0, want(model[5], 1, 0)});
    model[5] = model[5] ^ 32'h8000_8000;
    // R7 collision: write word 9 while looking up index 18
    pix_idx = 8'd18; reg_we = 1; reg_word = 7'd9; reg_wdata = 32'h1234_7C1F; step();
    reg_we = 0;
    chk("R7 old value", {8'h0, pix_rgb}, {8'h0, want(model[9], 0, 0)});
    model[9] = 32'h1234_7C1F;
    step();
    chk("R7 new value", {8'h0, pix_rgb}, {8'h0, want(model[9], 0, 0)});
    chk("R5 after write", reg_rdata, model[9]);
    // R9 hold
    step();
    chk("R9 hold", {8'h0, pix_rgb}, {8'h0, want(model[9], 0, 0)});
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule